// File: doc/BRIEF.md
# Write-Once Clock Mode Register

This block is an 8-bit mode register on the CPU bus. It selects the clock source and the operating modes of the system. A single-cycle write strobe loads new data. A second flag marks bus writes that come from a read-modify-write bit-set or bit-clear instruction. From the stored value the block derives the clock controls: the main oscillator type, the clock division ratio, main and ring oscillator enables, and a double-speed enable that is only granted with a ceramic main source.

Three bits choose the main oscillator type and the operating mode: bit 5, bit 1 and bit 0. If runaway code rewrote these bits, the clock system could lock up. So they accept one write after reset and then freeze until the next reset. A read-modify-write aimed at any other bit also uses up that single chance, without changing the protected bits. After reset the system runs from the ring oscillator. Once software has settled the protected bits, the block switches the system clock request to the main source.

Top module: `clkmode_reg`

## Requirements
- R1: Asynchronous active-low reset loads the value 0xD8 (bits 7:6 = 11, bit 4 = 1, bit 3 = 1, all other bits 0) and clears the lock.
- R2: Every write, plain or read-modify-write, loads bits 7, 6, 4, 3 and 2 from the write data on the clock edge where the write strobe is high.
- R3: The first plain write after reset loads bits 5, 1 and 0 from the write data in that same cycle and sets the lock.
- R4: While the lock is set, no write changes bits 5, 1 or 0.
- R5: A read-modify-write (write strobe and read-modify-write flag both high) never changes bits 5, 1 or 0, and it sets the lock.
- R6: Only reset clears the lock. Once set, it stays set through any sequence of writes.
- R7: The oscillator-type output equals bit 5: 1 selects ceramic, 0 selects RC.
- R8: The division-ratio output equals bits 7:6 (11 is the slowest ratio). The main oscillator enable equals bit 4 and the ring oscillator enable equals bit 3, each active high.
- R9: The double-speed enable is high only when bit 1 and bit 5 are both 1. With RC selected it stays low.
- R10: The main-source select output is 0 from reset until the lock is set, and 1 from the cycle after the locking write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| wr_rmw | input | 1 | Marks the write as a read-modify-write bit operation |
| mode_q | output | 8 | Current register value |
| osc_ceramic | output | 1 | Main oscillator type: 1 ceramic, 0 RC |
| div_sel | output | 2 | Clock division ratio select |
| main_osc_en | output | 1 | Main oscillator run enable |
| ring_osc_en | output | 1 | Ring oscillator run enable |
| dbl_speed_en | output | 1 | Double-speed mode enable |
| main_src_sel | output | 1 | System clock taken from the main source |

## Verification
The bench tests several write patterns against the protected bits. It checks the first write after reset when that write is a plain write and when it is a read-modify-write, a second write that tries to flip bits 5, 1 and 0, and repeated resets in the middle of a random sequence. If the lock took effect one cycle too early, the first write would be dropped. If read-modify-write were treated as a plain write, the protected bits would change. If the lock were cleared by anything other than reset, later writes would alter the protected bits. The bench also requests double speed with RC selected; a missing gate there would wrongly enable double speed.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
   localparam int CM_DATA_W = 8;
   localparam int CM_DIV_W  = 2;
   localparam logic [CM_DATA_W-1:0] CM_PROT_MASK = 8'b0010_0011;
   localparam logic [CM_DATA_W-1:0] CM_RESET_VAL = 8'b1101_1000;

   typedef struct packed {
      logic                ceramic;
      logic [CM_DIV_W-1:0] div;
      logic                main_en;
      logic                ring_en;
      logic                dbl_en;
      logic                use_main;
   } clk_ctl_t;
endpackage

// File: rtl/clkmode_lock.sv
module clkmode_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   output logic lock_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q <= 1'b0;
      else if (wr_en) lock_q <= 1'b1;
   end

   // R6
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   // R3
   lock_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> lock_q);
endmodule

// File: rtl/clkmode_store.sv
module clkmode_store #(
   parameter int                 DATA_W    = 8,
   parameter logic [DATA_W-1:0]  PROT_MASK = 8'b0010_0011,
   parameter logic [DATA_W-1:0]  RESET_VAL = 8'b1101_1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_rmw,
   input  logic              lock_i,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] q
);
   localparam logic [DATA_W-1:0] FREE_MASK = ~PROT_MASK;

   logic prot_ld;
   assign prot_ld = wr_en & ~wr_rmw & ~lock_i;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (PROT_MASK[b]) begin : g_prot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[b] <= RESET_VAL[b];
            else if (prot_ld) q[b] <= wr_data[b];
         end
      end else begin : g_free
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[b] <= RESET_VAL[b];
            else if (wr_en) q[b] <= wr_data[b];
         end
      end
   end

   // R2
   free_bits_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((q & FREE_MASK) == ($past(wr_data) & FREE_MASK)));

   // R3
   first_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_rmw && !lock_i) |=> ((q & PROT_MASK) == ($past(wr_data) & PROT_MASK)));

   // R4
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> ((q & PROT_MASK) == ($past(q) & PROT_MASK)));

   // R5
   rmw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_rmw) |=> ((q & PROT_MASK) == ($past(q) & PROT_MASK)));
endmodule

// File: rtl/clkmode_decode.sv
module clkmode_decode
   import clkmode_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int SRC_BIT  = 5,
   parameter int DBL_BIT  = 1,
   parameter int MAIN_BIT = 4,
   parameter int RING_BIT = 3,
   parameter int DIV_LSB  = 6
) (
   input  logic [DATA_W-1:0] mode_i,
   input  logic              lock_i,
   output clk_ctl_t          ctl
);
   always_comb begin
      ctl.ceramic  = mode_i[SRC_BIT];
      ctl.div      = mode_i[DIV_LSB +: CM_DIV_W];
      ctl.main_en  = mode_i[MAIN_BIT];
      ctl.ring_en  = mode_i[RING_BIT];
      ctl.dbl_en   = mode_i[DBL_BIT] & mode_i[SRC_BIT];
      ctl.use_main = lock_i;
   end
endmodule

// File: rtl/clkmode_reg.sv
module clkmode_reg
   import clkmode_pkg::*;
#(
   parameter int                DATA_W    = CM_DATA_W,
   parameter logic [DATA_W-1:0] PROT_MASK = CM_PROT_MASK,
   parameter logic [DATA_W-1:0] RESET_VAL = CM_RESET_VAL,
   parameter int                SRC_BIT   = 5,
   parameter int                DBL_BIT   = 1,
   parameter int                MAIN_BIT  = 4,
   parameter int                RING_BIT  = 3,
   parameter int                DIV_LSB   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_rmw,
   output logic [DATA_W-1:0] mode_q,
   output logic              osc_ceramic,
   output logic [CM_DIV_W-1:0] div_sel,
   output logic              main_osc_en,
   output logic              ring_osc_en,
   output logic              dbl_speed_en,
   output logic              main_src_sel
);
   if (DIV_LSB + CM_DIV_W > DATA_W) begin : g_bad_div
      $error("division field exceeds register width");
   end
   if (!PROT_MASK[SRC_BIT] || !PROT_MASK[DBL_BIT]) begin : g_bad_mask
      $error("source and speed bits must be protected");
   end
   if (PROT_MASK[MAIN_BIT] || PROT_MASK[RING_BIT]) begin : g_bad_free
      $error("oscillator enables must stay writable");
   end

   logic     lock_q;
   clk_ctl_t ctl;

   clkmode_lock u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .lock_q (lock_q)
   );

   clkmode_store #(
      .DATA_W    (DATA_W),
      .PROT_MASK (PROT_MASK),
      .RESET_VAL (RESET_VAL)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_rmw  (wr_rmw),
      .lock_i  (lock_q),
      .wr_data (wr_data),
      .q       (mode_q)
   );

   clkmode_decode #(
      .DATA_W   (DATA_W),
      .SRC_BIT  (SRC_BIT),
      .DBL_BIT  (DBL_BIT),
      .MAIN_BIT (MAIN_BIT),
      .RING_BIT (RING_BIT),
      .DIV_LSB  (DIV_LSB)
   ) u_decode (
      .mode_i (mode_q),
      .lock_i (lock_q),
      .ctl    (ctl)
   );

   assign osc_ceramic  = ctl.ceramic;
   assign div_sel      = ctl.div;
   assign main_osc_en  = ctl.main_en;
   assign ring_osc_en  = ctl.ring_en;
   assign dbl_speed_en = ctl.dbl_en;
   assign main_src_sel = ctl.use_main;

   // R10
   main_src_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_src_sel) |-> $past(wr_en));

   // R10
   main_src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      main_src_sel |=> main_src_sel);
endmodule

// File: tb/clkmode_reg_bench.sv
module clkmode_reg_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       wr_rmw = 1'b0;
   logic [7:0] mode_q;
   logic       osc_ceramic, main_osc_en, ring_osc_en, dbl_speed_en, main_src_sel;
   logic [1:0] div_sel;

   int checks = 0;
   int failures = 0;
   logic [7:0] exp_q;
   logic       exp_lock;

   always #5 clk = ~clk;

   clkmode_reg u_clkmode_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_rmw(wr_rmw),
      .mode_q(mode_q), .osc_ceramic(osc_ceramic), .div_sel(div_sel),
      .main_osc_en(main_osc_en), .ring_osc_en(ring_osc_en),
      .dbl_speed_en(dbl_speed_en), .main_src_sel(main_src_sel)
   );

   function automatic logic [7:0] next_val(logic [7:0] cur, logic [7:0] d, logic rmw, logic lk);
      logic [7:0] prot = 8'b0010_0011;
      if (!rmw && !lk) return d;
      return (d & ~prot) | (cur & prot);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic check_all();
      chk("R2/R3/R4/R5 value", {24'h0, mode_q}, {24'h0, exp_q});
      chk("R7 osc type", {31'h0, osc_ceramic}, {31'h0, exp_q[5]});
      chk("R8 div", {30'h0, div_sel}, {30'h0, exp_q[7:6]});
      chk("R8 main en", {31'h0, main_osc_en}, {31'h0, exp_q[4]});
      chk("R8 ring en", {31'h0, ring_osc_en}, {31'h0, exp_q[3]});
      chk("R9 double speed", {31'h0, dbl_speed_en}, {31'h0, exp_q[1] & exp_q[5]});
      chk("R10/R6 main src", {31'h0, main_src_sel}, {31'h0, exp_lock});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      exp_q = 8'hD8;
      exp_lock = 1'b0;
      chk("R1 reset value", {24'h0, mode_q}, 32'hD8);
      chk("R1 lock clear", {31'h0, main_src_sel}, 32'h0);
      rst_n = 1'b1;
   endtask

   task automatic do_write(logic [7:0] d, logic rmw);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d; wr_rmw = rmw;
      @(negedge clk);
      wr_en = 1'b0; wr_rmw = 1'b0;
      exp_q = next_val(exp_q, d, rmw, exp_lock);
      exp_lock = 1'b1;
      check_all();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      exp_q = 8'hD8; exp_lock = 1'b0;
      do_reset();
      check_all();
      // R3: first plain write loads protected bits, ceramic + double speed
      do_write(8'b0110_0010, 1'b0);
      // R4: protected bits frozen, RC attempt ignored
      do_write(8'b1001_1101, 1'b0);
      chk("R4 bit5 kept", {31'h0, mode_q[5]}, 32'h1);
      // R5: rmw as first access keeps protected bits, locks
      do_reset();
      do_write(8'b0011_0111, 1'b1);
      chk("R5 protected kept", {29'h0, mode_q[5], mode_q[1:0]}, 32'h0);
      do_write(8'b1110_0011, 1'b0);
      chk("R6 still locked", {29'h0, mode_q[5], mode_q[1:0]}, 32'h0);
      // R9: RC with double-speed request
      do_reset();
      do_write(8'b0000_0010, 1'b0);
      chk("R9 RC forces off", {31'h0, dbl_speed_en}, 32'h0);
      // random mix
      for (int i = 0; i < 400; i++) begin
         int r = $urandom_range(0, 19);
         if (r == 0) do_reset();
         else do_write(8'($urandom), (r < 6));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule